// File: doc/BRIEF.md
# Strided Block DMA Engine

This engine copies bytes between a small on-chip scratch memory (two 4 KiB banks) and a larger external DRAM. A transfer is a rectangle: a number of rows, each a whole number of 8-byte units long. On the DRAM side a programmable gap is left between rows. The local side stays packed. Software first loads a local start address and a DRAM start address. It then writes one of two length words. The register it writes chooses the direction and starts the transfer at once.

Both memories are reached through plain synchronous single-port byte interfaces with one cycle of read latency. The engine reads one byte from the source in a cycle and writes it to the destination in the following cycle. Reads and writes overlap, so one byte moves per cycle. There is no valid/ready back-pressure on either memory port: both memories must accept a request in every cycle the enable is high. The configuration port is likewise a plain write strobe with no handshake. A busy flag and a one-cycle done pulse report progress. A length write that arrives while a transfer runs is dropped.

Top module: `blkmove_dma`

## Requirements
- R1: The row length in bytes is the length word's bits [11:0] with its three low bits forced to one, plus one (8 to 4096 bytes).
- R2: The row count is length-word bits [19:12] plus one (1 to 256 rows). A transfer moves exactly rows x row-length bytes.
- R3: After each row, the length word's bits [31:20] plus one are added to the DRAM address. The local offset just continues by one, and DRAM bytes in the gap are not touched.
- R4: Local address bit 12 selects the bank for the whole transfer. Bits [11:0] are a byte offset that wraps modulo 4096 inside that bank.
- R5: Only bits [23:0] of the DRAM address register are used; the upper bits written to it have no effect.
- R6: Configuration selects are 0 = local address, 1 = DRAM address, 2 = length word for DRAM-to-local, 3 = length word for local-to-DRAM. Writing select 2 or 3 starts a transfer in that direction.
- R7: Inside a row, the local and DRAM logical addresses both increase by one for each byte moved.
- R8: Busy is high from the cycle after the starting length write for rows x row-length + 1 cycles. Done is high for exactly one cycle right after busy falls, and never while busy.
- R9: A length write while busy is ignored: the running transfer's byte count, duration and data are unchanged, and no second transfer follows.
- R10: Each memory port drives its address with the low three bits XORed with a per-port parameter (3 on both ports by default). The first DRAM access of a transfer therefore appears at the start address with bits [2:0] XORed with 3.
- R11: A byte read from the source in one cycle is written to the destination in the next cycle, from the source's read data. The two memories are never both written in the same cycle.
- R12: After reset, busy, done and both memory enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| loc_en | output | 1 | Local memory access enable |
| loc_we | output | 1 | Local memory write enable |
| loc_addr | output | 13 | Local physical byte address (bit 12 = bank) |
| loc_wdata | output | 8 | Local write byte |
| loc_rdata | input | 8 | Local read byte, one cycle after a read |
| dram_en | output | 1 | DRAM access enable |
| dram_we | output | 1 | DRAM write enable |
| dram_addr | output | 24 | DRAM physical byte address |
| dram_wdata | output | 8 | DRAM write byte |
| dram_rdata | input | 8 | DRAM read byte, one cycle after a read |

## Verification
Some properties are checked on every cycle. These are the byte-by-byte stepping of the local offset with its in-bank wrap, the unit step of the DRAM address inside a row, and the row counter holding until a row ends. They also cover the bank bit staying fixed across consecutive accesses, the exclusion of done and busy, the single-cycle done, and the rule that only one memory is written at a time. The bench's scenarios are needed to show the decoded row length and count, the skip applied only between rows with gap bytes left alone, and the address-bit XOR. They also show that the bytes arrive intact in the right places, that busy lasts the exact number of cycles, and that a length write during a transfer is dropped.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
  localparam int WORD_W = 32;
  localparam int OFF_W  = 12;            // byte offset inside one local bank
  localparam int ROW_W  = 8;             // row-count field width
  localparam int SKIP_W = WORD_W - OFF_W - ROW_W;
  localparam int UNIT_W = OFF_W - 3;     // row length in 8-byte units

  typedef enum logic [1:0] {
    SEL_LOC     = 2'd0,
    SEL_DRAM    = 2'd1,
    SEL_LEN_IN  = 2'd2,
    SEL_LEN_OUT = 2'd3
  } cfg_sel_e;

  typedef enum logic {
    DIR_IN  = 1'b0,   // DRAM -> local
    DIR_OUT = 1'b1    // local -> DRAM
  } xfer_dir_e;

  typedef struct packed {
    logic [SKIP_W-1:0] skip;
    logic [ROW_W-1:0]  rows_m1;
    logic [UNIT_W-1:0] units;
    logic [2:0]        lsb;
  } len_word_t;
endpackage

// File: rtl/blkmove_lane.sv
module blkmove_lane #(
  parameter int AW = 24,
  parameter int LANE_W = 3,
  parameter logic [LANE_W-1:0] SWZ = '0
) (
  input  logic [AW-1:0] la,
  output logic [AW-1:0] pa
);
  generate
    if (SWZ == '0) begin : g_plain
      assign pa = la;
    end else begin : g_swz
      assign pa = {la[AW-1:LANE_W], la[LANE_W-1:0] ^ SWZ};
    end
  endgenerate
endmodule

// File: rtl/blkmove_regs.sv
module blkmove_regs
  import blkmove_pkg::*;
#(
  parameter int DRAM_AW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [WORD_W-1:0]    cfg_wdata,
  input  logic                 busy,
  output logic [OFF_W:0]       loc_base,
  output logic [DRAM_AW-1:0]   dram_base,
  output logic                 start,
  output xfer_dir_e            start_dir,
  output len_word_t            start_len
);
  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_base  <= '0;
      dram_base <= '0;
    end else if (cfg_we) begin
      if (sel == SEL_LOC)  loc_base  <= cfg_wdata[OFF_W:0];
      if (sel == SEL_DRAM) dram_base <= cfg_wdata[DRAM_AW-1:0];
    end
  end

  always_comb begin
    start     = cfg_we && !busy && (sel == SEL_LEN_IN || sel == SEL_LEN_OUT);
    start_dir = (sel == SEL_LEN_OUT) ? DIR_OUT : DIR_IN;
    start_len = len_word_t'(cfg_wdata);
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R6
endmodule

// File: rtl/blkmove_seq.sv
module blkmove_seq
  import blkmove_pkg::*;
#(
  parameter int DRAM_AW = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  xfer_dir_e          start_dir,
  input  len_word_t          start_len,
  input  logic [OFF_W:0]     loc_base,
  input  logic [DRAM_AW-1:0] dram_base,
  input  logic [7:0]         loc_rdata,
  input  logic [7:0]         dram_rdata,
  output logic               busy,
  output logic               done,
  output logic               loc_en,
  output logic               loc_we,
  output logic [OFF_W:0]     loc_la,
  output logic [7:0]         loc_wdata,
  output logic               dram_en,
  output logic               dram_we,
  output logic [DRAM_AW-1:0] dram_la,
  output logic [7:0]         dram_wdata
);
  logic               iss_q, pend_q, done_q, bank_q;
  xfer_dir_e          dir_q;
  logic [OFF_W-1:0]   off_q, pend_off_q, col_q, col_init_q;
  logic [DRAM_AW-1:0] da_q, pend_da_q;
  logic [ROW_W-1:0]   rows_q;
  logic [SKIP_W-1:0]  skip_q;
  logic               row_end;

  assign row_end = (col_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_q <= 1'b0; pend_q <= 1'b0; done_q <= 1'b0; bank_q <= 1'b0;
      dir_q <= DIR_IN; off_q <= '0; pend_off_q <= '0; col_q <= '0;
      col_init_q <= '0; da_q <= '0; pend_da_q <= '0; rows_q <= '0; skip_q <= '0;
    end else begin
      done_q <= pend_q && !iss_q;
      if (start) begin
        iss_q      <= 1'b1;
        pend_q     <= 1'b0;
        dir_q      <= start_dir;
        bank_q     <= loc_base[OFF_W];
        off_q      <= loc_base[OFF_W-1:0];
        da_q       <= dram_base;
        col_init_q <= {start_len.units, 3'b111};
        col_q      <= {start_len.units, 3'b111};
        rows_q     <= start_len.rows_m1;
        skip_q     <= start_len.skip;
      end else begin
        pend_q <= iss_q;
        if (iss_q) begin
          pend_off_q <= off_q;
          pend_da_q  <= da_q;
          off_q      <= off_q + 1'b1;
          if (row_end) begin
            col_q <= col_init_q;
            da_q  <= da_q + DRAM_AW'(skip_q) + 1'b1;
            if (rows_q == '0) iss_q <= 1'b0;
            else              rows_q <= rows_q - 1'b1;
          end else begin
            col_q <= col_q - 1'b1;
            da_q  <= da_q + 1'b1;
          end
        end
      end
    end
  end

  logic rd_loc, wr_loc, rd_dram, wr_dram;
  always_comb begin
    rd_loc     = iss_q  && (dir_q == DIR_OUT);
    wr_loc     = pend_q && (dir_q == DIR_IN);
    rd_dram    = iss_q  && (dir_q == DIR_IN);
    wr_dram    = pend_q && (dir_q == DIR_OUT);
    busy       = iss_q | pend_q;
    done       = done_q;
    loc_en     = rd_loc | wr_loc;
    loc_we     = wr_loc;
    loc_la     = {bank_q, wr_loc ? pend_off_q : off_q};
    loc_wdata  = dram_rdata;
    dram_en    = rd_dram | wr_dram;
    dram_we    = wr_dram;
    dram_la    = wr_dram ? pend_da_q : da_q;
    dram_wdata = loc_rdata;
  end

  AST_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_q && $past(iss_q)) |-> off_q == OFF_W'($past(off_q) + 1'b1)); // R4
  AST_DRAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_q && $past(iss_q) && $past(col_q) != '0) |-> da_q == DRAM_AW'($past(da_q) + 1'b1)); // R7
  AST_ROWS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_q && $past(iss_q) && $past(col_q) != '0) |-> rows_q == $past(rows_q)); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
endmodule

// File: rtl/blkmove_dma.sv
module blkmove_dma
  import blkmove_pkg::*;
#(
  parameter int DRAM_AW = 24,
  parameter int LANE_W = 3,
  parameter logic [LANE_W-1:0] LOC_SWZ = 3'd3,
  parameter logic [LANE_W-1:0] DRAM_SWZ = 3'd3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [31:0]        cfg_wdata,
  output logic               busy,
  output logic               done,
  output logic               loc_en,
  output logic               loc_we,
  output logic [12:0]        loc_addr,
  output logic [7:0]         loc_wdata,
  input  logic [7:0]         loc_rdata,
  output logic               dram_en,
  output logic               dram_we,
  output logic [DRAM_AW-1:0] dram_addr,
  output logic [7:0]         dram_wdata,
  input  logic [7:0]         dram_rdata
);
  localparam int LOC_AW = OFF_W + 1;

  logic [OFF_W:0]     loc_base, loc_la;
  logic [DRAM_AW-1:0] dram_base, dram_la;
  logic               start;
  xfer_dir_e          start_dir;
  len_word_t          start_len;

  blkmove_regs #(.DRAM_AW(DRAM_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .loc_base(loc_base),
    .dram_base(dram_base), .start(start), .start_dir(start_dir),
    .start_len(start_len)
  );

  blkmove_seq #(.DRAM_AW(DRAM_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
    .start_len(start_len), .loc_base(loc_base), .dram_base(dram_base),
    .loc_rdata(loc_rdata), .dram_rdata(dram_rdata), .busy(busy), .done(done),
    .loc_en(loc_en), .loc_we(loc_we), .loc_la(loc_la), .loc_wdata(loc_wdata),
    .dram_en(dram_en), .dram_we(dram_we), .dram_la(dram_la),
    .dram_wdata(dram_wdata)
  );

  blkmove_lane #(.AW(LOC_AW), .LANE_W(LANE_W), .SWZ(LOC_SWZ)) u_loc_lane (
    .la(loc_la), .pa(loc_addr)
  );

  blkmove_lane #(.AW(DRAM_AW), .LANE_W(LANE_W), .SWZ(DRAM_SWZ)) u_dram_lane (
    .la(dram_la), .pa(dram_addr)
  );

  AST_BANK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_en && $past(loc_en)) |-> loc_addr[OFF_W] == $past(loc_addr[OFF_W])); // R4
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_en && loc_we && dram_en && dram_we)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(loc_en || dram_en)); // R12
endmodule

// File: tb/blkmove_dma_bench.sv
module blkmove_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        busy, done, loc_en, loc_we, dram_en, dram_we;
  logic [12:0] loc_addr;
  logic [23:0] dram_addr;
  logic [7:0]  loc_wdata, dram_wdata;
  logic [7:0]  loc_rdata = 8'd0;
  logic [7:0]  dram_rdata = 8'd0;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  blkmove_dma u_blkmove_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .done(done), .loc_en(loc_en),
    .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata), .dram_en(dram_en), .dram_we(dram_we),
    .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
  );

  function automatic logic [7:0] lpat(int a);
    return 8'(a * 5 + (a >> 7) + 1);
  endfunction
  function automatic logic [7:0] dpat(int a);
    return 8'((a * 11) ^ (a >> 5) ^ 8'hC3);
  endfunction
  function automatic int swz(int a);
    return a ^ 3;
  endfunction

  // memory models: one cycle read latency, 64 KiB of DRAM modelled
  logic [7:0] lmem [0:8191];
  logic [7:0] dmem [0:65535];
  logic       init_req = 1'b0;
  int         wr_total = 0;
  logic       dram_en_d = 1'b0;
  logic [23:0] first_da = 24'd0;

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 8192; i++)  lmem[i] <= lpat(i);
      for (int i = 0; i < 65536; i++) dmem[i] <= dpat(i);
    end else begin
      if (loc_en) begin
        if (loc_we) lmem[loc_addr] <= loc_wdata;
        else        loc_rdata <= lmem[loc_addr];
      end
      if (dram_en) begin
        if (dram_we) dmem[dram_addr[15:0]] <= dram_wdata;
        else         dram_rdata <= dmem[dram_addr[15:0]];
      end
    end
    if ((loc_en && loc_we) || (dram_en && dram_we)) wr_total <= wr_total + 1;
    dram_en_d <= dram_en;
    if (dram_en && !dram_en_d) first_da <= dram_addr;
  end

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one full transfer with checks; inj >= 0 injects a length write at that busy cycle
  task automatic xfer(bit dir_out, logic [12:0] loc, logic [31:0] dram,
                      logic [31:0] len, int nbytes, int inj);
    int L, rows, skip, bank, off, w0, busy_n, done_n, bad, cyc;
    L    = (int'(len[11:0]) | 7) + 1;
    rows = int'(len[19:12]) + 1;
    skip = int'(len[31:20]);
    bank = int'(loc[12]);
    off  = int'(loc[11:0]);
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
    cfg_write(2'd0, {19'd0, loc});
    cfg_write(2'd1, dram);
    w0 = wr_total;
    cfg_write(dir_out ? 2'd3 : 2'd2, len);
    busy_n = 0; done_n = 0; cyc = 0;
    while (!done && cyc < 20000) begin
      if (busy) busy_n++;
      cfg_we = (cyc == inj);
      cfg_sel = 2'd3; cfg_wdata = 32'h0000_F0FF;
      @(negedge clk);
      cfg_we = 1'b0;
      cyc++;
    end
    if (done) done_n++;
    @(negedge clk);
    if (done) done_n++;
    repeat (3) begin
      if (busy) busy_n++;
      @(negedge clk);
    end
    check(busy_n == nbytes + 1, "R8 busy cycles", busy_n, nbytes + 1);
    check(done_n == 1, "R8 done pulse count", done_n, 1);
    check(wr_total - w0 == nbytes, "R1 R2 R9 bytes written", wr_total - w0, nbytes);
    check(first_da == 24'(swz(int'(dram[23:0]))), "R10 R5 first DRAM address",
          int'(first_da), swz(int'(dram[23:0])));
    bad = 0;
    for (int r = 0; r < rows; r++) begin
      for (int j = 0; j < L; j++) begin
        int la, da;
        la = bank * 4096 + ((off + r * L + j) & 12'hFFF);
        da = (int'(dram[23:0]) + r * (L + skip) + j) & 16'hFFFF;
        if (dir_out) begin
          if (dmem[swz(da)] !== lpat(swz(la))) bad++;
        end else begin
          if (lmem[swz(la)] !== dpat(swz(da))) bad++;
        end
      end
    end
    check(bad == 0, "R3 R4 R7 R11 data placement", bad, 0);
    if (dir_out) begin
      int ga;
      ga = swz((int'(dram[23:0]) + L) & 16'hFFFF);
      check(skip == 0 || dmem[ga] === dpat(ga), "R3 gap byte untouched",
            int'(dmem[ga]), int'(dpat(ga)));
    end else begin
      int oa;
      oa = swz((1 - bank) * 4096 + off);
      check(lmem[oa] === lpat(oa), "R4 other bank untouched",
            int'(lmem[oa]), int'(lpat(oa)));
    end
  endtask

  typedef struct packed {
    logic        dir_out;
    logic [12:0] loc;
    logic [31:0] dram;
    logic [31:0] len;
    logic [31:0] nbytes;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 13'h0000, 32'h0000_0100, 32'h0000_0000, 32'd8},
    '{1'b0, 13'h0010, 32'h0000_2005, 32'h0020_200A, 32'd48},
    '{1'b1, 13'h1020, 32'h0000_3000, 32'h0050_1010, 32'd48},
    '{1'b1, 13'h0FF8, 32'h0000_4000, 32'h0000_000F, 32'd16},
    '{1'b0, 13'h1FFC, 32'hFF00_0500, 32'h0000_3007, 32'd32},
    '{1'b1, 13'h0003, 32'h0000_0007, 32'h0090_001F, 32'd32}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(!busy && !done && !loc_en && !dram_en, "R12 reset outputs",
          {busy, done, loc_en, dram_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !loc_en && !dram_en, "R12 idle after reset",
          {busy, done, loc_en, dram_en}, 0);
    // R6: address writes alone start nothing
    cfg_write(2'd0, 32'h0000_0040);
    cfg_write(2'd1, 32'h0000_0080);
    @(negedge clk);
    check(!busy && !loc_en && !dram_en, "R6 address writes do not start",
          {busy, loc_en, dram_en}, 0);
    for (int v = 0; v < 6; v++)
      xfer(VECS[v].dir_out, VECS[v].loc, VECS[v].dram, VECS[v].len,
           int'(VECS[v].nbytes), -1);
    // R9: length write in mid-transfer dropped
    xfer(1'b1, 13'h0100, 32'h0000_6000, 32'h0000_000F, 16, 5);
    xfer(1'b0, 13'h0200, 32'h0000_7000, 32'h0000_1008, 32, 30);
    @(negedge clk);
    check(!busy, "R9 no follow-on transfer", busy, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule